// File: doc/BRIEF.md
# Windowed Bus Address Translator

This block remaps 64-bit bus addresses through a small set of programmable windows. Each direction, inbound and outbound, has its own set of regions. A region holds a start address, an inclusive end address and a target address. If an address falls inside an enabled region, the block replaces it with the target address plus the address's offset from the region start. If an address matches no enabled region, the block passes it through unchanged.

Software programs the regions through a 32-bit register port that uses indirection. A viewport register selects one region and one direction. The control, base, limit and target registers then read and write that region's fields. The upper 32 bits of a region's end address come from its upper base word, so each region stores only a 32-bit limit word. Lookups take an address, a direction bit and a valid strobe. The result appears one clock later as a translated address and a hit flag.

Top module: `addr_xlate_unit`

## Requirements
- R1: Reset does four things: it disables every region in both directions, clears the viewport to 0 and clears all region fields to 0, and it drives `outValid` low. After reset, any lookup misses.
- R2: The viewport register sits at word offset 0. Bits [3:0] hold the region index and bit 31 selects the direction (1 = inbound, 0 = outbound). Reading it returns the value last written in those bits, with all other bits reading 0.
- R3: Each word offset below reads back the last value written to it, for the region and direction that the viewport selects: 1 = control (enable in bit 0), 2 = base low, 3 = base high, 4 = limit, 5 = target low, 6 = target high. Offset 7 reads 0. A region's inbound and outbound fields are separate storage.
- R4: The region start is {base high, base low} and the end is {base high, limit}. Both bounds are inclusive. An address whose upper 32 bits differ from base high never matches.
- R5: On a hit, `outAddr` = {target high, target low} + (address − start) and `outHit` = 1.
- R6: On a miss, `outAddr` equals the input address and `outHit` = 0.
- R7: A region takes part in matching only while its enable bit is 1. Clearing the bit removes the region from matching.
- R8: When several enabled regions match, the region with the lowest index supplies the result.
- R9: `outValid` is high exactly in the cycle after a cycle with `xlValid` high. `outAddr` and `outHit` belong to that request.
- R10: A region whose target equals its base translates every address inside it to itself, with `outHit` = 1.
- R11: While the viewport index is 4 or more (not below NUM_REGIONS), writes to offsets 1..6 change nothing and reads of offsets 1..6 return 0.
- R12: An inbound lookup uses only inbound regions, and an outbound lookup uses only outbound regions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Register write enable |
| cfgAddr | input | 3 | Register word offset |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data (combinational on cfgAddr) |
| xlValid | input | 1 | Lookup request valid |
| xlInbound | input | 1 | Lookup direction, 1 = inbound |
| xlAddr | input | 64 | Address to translate |
| outValid | output | 1 | Result valid, one cycle after request |
| outHit | output | 1 | Result came from a region |
| outAddr | output | 64 | Translated or passed-through address |

## Verification
The main lookup function is tried with several address patterns, each chosen to separate one cause from another:
- Addresses on the first and last byte of a window, and one address just outside each end, separate inclusive bounds from exclusive ones.
- An address whose low word fits a window but whose high word differs shows that the end address borrows its upper half from the base.
- An address covered by two overlapping regions, tried before and after the lower region is disabled, separates priority order from enable gating.
- Outbound lookups of an inbound-only window, and a write made while the viewport selects an index beyond the region count, show that directions and out-of-range regions stay isolated.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 2 * REG_W;
  localparam int VP_IDX_W  = 4;
  localparam int VP_DIR_B  = 31;
  localparam int OFS_W     = 3;

  localparam logic [OFS_W-1:0] OFS_VIEW   = 3'd0;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_BASELO = 3'd2;
  localparam logic [OFS_W-1:0] OFS_BASEHI = 3'd3;
  localparam logic [OFS_W-1:0] OFS_LIMIT  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_TGTLO  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_TGTHI  = 3'd6;

  typedef struct packed {
    logic                inbound;
    logic [VP_IDX_W-1:0] region;
    logic                selOk;
    logic                wrCtrl;
    logic                wrBaseLo;
    logic                wrBaseHi;
    logic                wrLimit;
    logic                wrTgtLo;
    logic                wrTgtHi;
  } cfgStrobe_t;

  typedef struct packed {
    logic             enable;
    logic [REG_W-1:0] baseLo;
    logic [REG_W-1:0] baseHi;
    logic [REG_W-1:0] limit;
    logic [REG_W-1:0] tgtLo;
    logic [REG_W-1:0] tgtHi;
  } regionCfg_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWe,
  input  logic [OFS_W-1:0] cfgAddr,
  input  logic [REG_W-1:0] cfgWdata,
  output logic [REG_W-1:0] cfgRdata,
  output cfgStrobe_t       strobe,
  input  regionCfg_t       selCfg
);
  logic [VP_IDX_W-1:0] vpIndex;
  logic                vpInbound;
  logic                unusedWdata;
  logic                selOk;
  logic                wrView;

  assign unusedWdata = ^cfgWdata[VP_DIR_B-1:VP_IDX_W];
  assign selOk       = (int'(vpIndex) < NUM_REGIONS);
  assign wrView      = cfgWe && (cfgAddr == OFS_VIEW);

  always_ff @(posedge clk) begin
    if (rst) begin
      vpIndex   <= '0;
      vpInbound <= 1'b0;
    end else if (wrView) begin
      vpIndex   <= cfgWdata[VP_IDX_W-1:0];
      vpInbound <= cfgWdata[VP_DIR_B];
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.inbound  = vpInbound;
    strobe.region   = vpIndex;
    strobe.selOk    = selOk;
    if (cfgWe && selOk) begin
      strobe.wrCtrl   = (cfgAddr == OFS_CTRL);
      strobe.wrBaseLo = (cfgAddr == OFS_BASELO);
      strobe.wrBaseHi = (cfgAddr == OFS_BASEHI);
      strobe.wrLimit  = (cfgAddr == OFS_LIMIT);
      strobe.wrTgtLo  = (cfgAddr == OFS_TGTLO);
      strobe.wrTgtHi  = (cfgAddr == OFS_TGTHI);
    end
  end

  always_comb begin
    cfgRdata = '0;
    case (cfgAddr)
      OFS_VIEW: begin
        cfgRdata[VP_IDX_W-1:0] = vpIndex;
        cfgRdata[VP_DIR_B]     = vpInbound;
      end
      OFS_CTRL:   cfgRdata[0] = selCfg.enable;
      OFS_BASELO: cfgRdata    = selCfg.baseLo;
      OFS_BASEHI: cfgRdata    = selCfg.baseHi;
      OFS_LIMIT:  cfgRdata    = selCfg.limit;
      OFS_TGTLO:  cfgRdata    = selCfg.tgtLo;
      OFS_TGTHI:  cfgRdata    = selCfg.tgtHi;
      default:    cfgRdata    = '0;
    endcase
  end

  assert_viewport_R2: assert property (@(posedge clk) disable iff (rst)
    wrView |=> (vpIndex == $past(cfgWdata[VP_IDX_W-1:0]) &&
                vpInbound == $past(cfgWdata[VP_DIR_B])));
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  cfgStrobe_t        strobe,
  input  logic [REG_W-1:0]  cfgWdata,
  output regionCfg_t        selCfg,
  input  logic              xlValid,
  input  logic              xlInbound,
  input  logic [ADDR_W-1:0] xlAddr,
  output logic              outValid,
  output logic              outHit,
  output logic [ADDR_W-1:0] outAddr
);
  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  regionCfg_t        cfgMem [2][NUM_REGIONS];
  logic [RIDX_W-1:0] regionIdx;
  logic              unusedRegion;
  logic [NUM_REGIONS-1:0] hitVec;
  logic [ADDR_W-1:0] xlated [NUM_REGIONS];
  logic              anyHit;
  logic [ADDR_W-1:0] nextAddr;
  logic              anyEnabled;

  assign regionIdx    = strobe.region[RIDX_W-1:0];
  assign unusedRegion = ^strobe.region;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < 2; d++)
        for (int r = 0; r < NUM_REGIONS; r++)
          cfgMem[d][r] <= '0;
    end else if (strobe.selOk) begin
      if (strobe.wrCtrl)   cfgMem[strobe.inbound][regionIdx].enable <= cfgWdata[0];
      if (strobe.wrBaseLo) cfgMem[strobe.inbound][regionIdx].baseLo <= cfgWdata;
      if (strobe.wrBaseHi) cfgMem[strobe.inbound][regionIdx].baseHi <= cfgWdata;
      if (strobe.wrLimit)  cfgMem[strobe.inbound][regionIdx].limit  <= cfgWdata;
      if (strobe.wrTgtLo)  cfgMem[strobe.inbound][regionIdx].tgtLo  <= cfgWdata;
      if (strobe.wrTgtHi)  cfgMem[strobe.inbound][regionIdx].tgtHi  <= cfgWdata;
    end
  end

  assign selCfg = strobe.selOk ? cfgMem[strobe.inbound][regionIdx] : '0;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    regionCfg_t        rc;
    logic [ADDR_W-1:0] startAddr;
    logic [ADDR_W-1:0] endAddr;
    assign rc        = cfgMem[xlInbound][r];
    assign startAddr = {rc.baseHi, rc.baseLo};
    assign endAddr   = {rc.baseHi, rc.limit};
    assign hitVec[r] = rc.enable && (xlAddr >= startAddr) && (xlAddr <= endAddr);
    assign xlated[r] = {rc.tgtHi, rc.tgtLo} + (xlAddr - startAddr);
  end

  always_comb begin
    anyHit   = 1'b0;
    nextAddr = xlAddr;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (hitVec[r]) begin
        anyHit   = 1'b1;
        nextAddr = xlated[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outHit   <= 1'b0;
      outAddr  <= '0;
    end else begin
      outValid <= xlValid;
      if (xlValid) begin
        outHit  <= anyHit;
        outAddr <= nextAddr;
      end
    end
  end

  always_comb begin
    anyEnabled = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++)
      anyEnabled = anyEnabled | cfgMem[xlInbound][r].enable;
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (!rst && xlValid) |=> outValid);

  assert_passthru_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && xlValid) |=> (outHit || outAddr == $past(xlAddr)));

  assert_disabled_miss_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && xlValid && !anyEnabled) |=> !outHit);
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import xlate_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfgWe,
  input  logic [2:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  input  logic        xlValid,
  input  logic        xlInbound,
  input  logic [63:0] xlAddr,
  output logic        outValid,
  output logic        outHit,
  output logic [63:0] outAddr
);
  cfgStrobe_t strobe;
  regionCfg_t selCfg;

  xlate_ctrl #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .strobe(strobe), .selCfg(selCfg)
  );

  xlate_dp #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cfgWdata(cfgWdata), .selCfg(selCfg),
    .xlValid(xlValid), .xlInbound(xlInbound), .xlAddr(xlAddr),
    .outValid(outValid), .outHit(outHit), .outAddr(outAddr)
  );

  assert_reset_out_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !outValid);
endmodule

// File: tb/addr_xlate_unit_tb.sv
module addr_xlate_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        xlValid = 1'b0;
  logic        xlInbound = 1'b0;
  logic [63:0] xlAddr = '0;
  logic        outValid, outHit;
  logic [63:0] outAddr;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  addr_xlate_unit u_dut (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .xlValid(xlValid), .xlInbound(xlInbound), .xlAddr(xlAddr),
    .outValid(outValid), .outHit(outHit), .outAddr(outAddr)
  );

  typedef struct packed {
    logic        inb;
    logic [63:0] addr;
    logic        hit;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 64'h0000_0000_8000_0000, 1'b1, 64'h0000_0001_0000_0000}, // R4 start
    '{1'b1, 64'h0000_0000_BFFF_FFFF, 1'b1, 64'h0000_0001_3FFF_FFFF}, // R4 end, R5
    '{1'b1, 64'h0000_0000_C000_0000, 1'b0, 64'h0000_0000_C000_0000}, // R6 above
    '{1'b1, 64'h0000_0000_7FFF_FFFF, 1'b0, 64'h0000_0000_7FFF_FFFF}, // R6 below
    '{1'b1, 64'h0000_0000_A000_0010, 1'b1, 64'h0000_0001_2000_0010}, // R8 overlap
    '{1'b1, 64'h0000_0002_0000_1800, 1'b1, 64'h0000_0002_0000_1800}, // R10
    '{1'b1, 64'h0000_0002_0000_2000, 1'b0, 64'h0000_0002_0000_2000}, // R4 limit+1
    '{1'b1, 64'h0000_0003_0000_0040, 1'b0, 64'h0000_0003_0000_0040}, // R7 disabled
    '{1'b1, 64'h0000_0001_8000_0000, 1'b0, 64'h0000_0001_8000_0000}, // R4 upper half
    '{1'b0, 64'h0000_0000_8000_0010, 1'b1, 64'h0000_0000_0000_0010}, // R12 outbound
    '{1'b0, 64'h0000_0000_A000_0000, 1'b0, 64'h0000_0000_A000_0000}, // R12 isolation
    '{1'b0, 64'h0000_0000_8001_0000, 1'b0, 64'h0000_0000_8001_0000}, // R4 outbound end+1
    '{1'b0, 64'h0000_0000_8000_FFFF, 1'b1, 64'h0000_0000_0000_FFFF}  // R5 outbound end
  };

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfgWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdata;
  endtask

  task automatic selectRegion(logic inb, logic [3:0] idx);
    cfgWrite(3'd0, {inb, 27'd0, idx});
  endtask

  task automatic setRegion(logic inb, logic [3:0] idx, logic [31:0] bLo, logic [31:0] bHi,
                           logic [31:0] lim, logic [31:0] tLo, logic [31:0] tHi, logic en);
    selectRegion(inb, idx);
    cfgWrite(3'd2, bLo);
    cfgWrite(3'd3, bHi);
    cfgWrite(3'd4, lim);
    cfgWrite(3'd5, tLo);
    cfgWrite(3'd6, tHi);
    cfgWrite(3'd1, {31'd0, en});
  endtask

  task automatic lookup(logic inb, logic [63:0] a, output logic v, output logic h,
                        output logic [63:0] o);
    @(negedge clk);
    xlValid = 1'b1; xlInbound = inb; xlAddr = a;
    @(negedge clk);
    xlValid = 1'b0;
    v = outValid; h = outHit; o = outAddr;
  endtask

  initial begin
    #4_000_000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        v, h;
    logic [63:0] o;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 outValid after reset", {63'd0, outValid}, 64'd0);
    cfgRead(3'd0, rd);
    check("R1 viewport after reset", {32'd0, rd}, 64'd0);
    cfgRead(3'd1, rd);
    check("R1 region disabled after reset", {32'd0, rd}, 64'd0);
    lookup(1'b1, 64'h0000_0000_8000_0000, v, h, o);
    check("R1 no hit after reset", {63'd0, h}, 64'd0);
    check("R6 passthru after reset", o, 64'h0000_0000_8000_0000);

    setRegion(1'b1, 4'd0, 32'h8000_0000, 32'h0, 32'hBFFF_FFFF, 32'h0, 32'h1, 1'b1);
    setRegion(1'b1, 4'd1, 32'hA000_0000, 32'h0, 32'hAFFF_FFFF, 32'h0, 32'h0, 1'b1);
    setRegion(1'b1, 4'd2, 32'h0000_1000, 32'h2, 32'h0000_1FFF, 32'h0000_1000, 32'h2, 1'b1);
    setRegion(1'b1, 4'd3, 32'h0, 32'h3, 32'hFFFF_FFFF, 32'h0, 32'h10, 1'b0);
    setRegion(1'b0, 4'd0, 32'h8000_0000, 32'h0, 32'h8000_FFFF, 32'h0, 32'h0, 1'b1);

    // R2 / R3 readback
    selectRegion(1'b1, 4'd1);
    cfgRead(3'd0, rd);
    check("R2 viewport readback", {32'd0, rd}, 64'h8000_0001);
    cfgRead(3'd2, rd);
    check("R3 base low readback", {32'd0, rd}, 64'hA000_0000);
    cfgRead(3'd4, rd);
    check("R3 limit readback", {32'd0, rd}, 64'hAFFF_FFFF);
    cfgRead(3'd7, rd);
    check("R3 offset 7 reads zero", {32'd0, rd}, 64'd0);
    selectRegion(1'b1, 4'd2);
    cfgRead(3'd6, rd);
    check("R3 target high readback", {32'd0, rd}, 64'h2);
    selectRegion(1'b0, 4'd1);
    cfgRead(3'd1, rd);
    check("R3 outbound separate from inbound", {32'd0, rd}, 64'd0);

    // R11 out-of-range index
    selectRegion(1'b1, 4'd5);
    cfgWrite(3'd2, 32'hDEAD_BEEF);
    cfgWrite(3'd1, 32'h1);
    cfgRead(3'd2, rd);
    check("R11 out-of-range read zero", {32'd0, rd}, 64'd0);
    selectRegion(1'b1, 4'd1);
    cfgRead(3'd2, rd);
    check("R11 region 1 untouched", {32'd0, rd}, 64'hA000_0000);
    selectRegion(1'b1, 4'd0);
    cfgRead(3'd2, rd);
    check("R11 region 0 untouched", {32'd0, rd}, 64'h8000_0000);

    // table of lookups (R4 R5 R6 R8 R10 R12)
    for (int i = 0; i < NVEC; i++) begin
      lookup(VEC[i].inb, VEC[i].addr, v, h, o);
      check($sformatf("R9 valid vec %0d", i), {63'd0, v}, 64'd1);
      check($sformatf("R5/R6 hit vec %0d", i), {63'd0, h}, {63'd0, VEC[i].hit});
      check($sformatf("R5/R6 addr vec %0d", i), o, VEC[i].exp);
    end

    // R9 valid drops after one cycle
    lookup(1'b1, 64'h0000_0000_8000_0004, v, h, o);
    @(negedge clk);
    check("R9 outValid single cycle", {63'd0, outValid}, 64'd0);
    check("R9 result held", outAddr, 64'h0000_0001_0000_0004);

    // R7 / R8: disable region 0, region 1 now wins
    selectRegion(1'b1, 4'd0);
    cfgWrite(3'd1, 32'h0);
    lookup(1'b1, 64'h0000_0000_A000_0010, v, h, o);
    check("R8 next region after disable hit", {63'd0, h}, 64'd1);
    check("R8 next region after disable addr", o, 64'h0000_0000_0000_0010);
    lookup(1'b1, 64'h0000_0000_B000_0000, v, h, o);
    check("R7 disabled region no hit", {63'd0, h}, 64'd0);
    check("R7 disabled region passthru", o, 64'h0000_0000_B000_0000);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule